// File: doc/BRIEF.md
# MOESI Snooping Cache Coherence Controller

This block sits beside one processor's private cache. It holds the tag, coherence state and one data word for each line of a small direct-mapped array. Local loads and stores are served from this array. Misses, upgrades and dirty evictions become transactions on a shared snooping bus. At the same time the block watches transactions that other caches place on that bus and answers them with a shared indication and, when it holds the only up-to-date copy, the data itself.

Every line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. Only Invalid means the line holds no data. Modified and Owned lines are newer than memory. Exclusive and Shared lines match memory. The Owned state allows dirty sharing: a Modified line that another cache reads is handed over directly, without a memory update, and this cache stays in Owned. It keeps the duty to write the line to memory when the line is evicted.

The processor keeps a request asserted until `busy_o` is low in the same cycle. The request is accepted at that clock edge, and `resp_valid_o` pulses in the cycle after the request completes. On the bus side the block holds `bus_req_o` together with its command and address until `bus_ack_i`. A fill or upgrade completes on the ack edge. The external arbiter grants one cache at a time and never acks in a cycle in which it presents a snoop to this cache. A snoop arrives as a one-cycle `snp_valid_i`, is answered combinationally in the same cycle, and updates the line state at the following edge.

Top module: `moesi_cc`

## Requirements
- R1: After reset every line is Invalid, `busy_o`, `bus_req_o` and `resp_valid_o` are low, and a snoop to any address gets neither shared nor supply.
- R2: A load that hits a valid line returns the line's data with `resp_valid_o` in the cycle after acceptance, and no bus transaction starts.
- R3: A load miss issues a read (`bus_cmd_o` = 0) for the request address. The line fills as Exclusive if `bus_shared_i` is low at the ack, otherwise as Shared. The fill data is returned in the cycle after the ack.
- R4: A store that hits an Exclusive or Modified line completes in the cycle after acceptance without a bus transaction, and the line becomes Modified.
- R5: A store that hits a Shared or Owned line issues an upgrade (`bus_cmd_o` = 2). After the ack the line is Modified and holds the store data.
- R6: A store miss issues a read-for-ownership (`bus_cmd_o` = 1). After the ack the line is Modified and holds the store data.
- R7: A miss whose victim is Modified or Owned first issues a writeback (`bus_cmd_o` = 3) carrying the victim's address and data, then issues the fetch. A clean or Invalid victim issues the fetch directly.
- R8: A snooped read (`snp_cmd_i` = 0) that hits a Modified line asserts shared and supply, drives the line data, and moves the line to Owned.
- R9: A snooped read that hits an Owned line supplies data and leaves it Owned. One that hits an Exclusive line asserts shared without supply and moves it to Shared. One that hits a Shared line asserts shared only.
- R10: A snooped read-for-ownership (1) or upgrade (2) that hits any valid line invalidates it. A read-for-ownership also supplies data from Modified or Owned. An upgrade never supplies. A snooped writeback (3) or a snoop that misses draws no answer.
- R11: `busy_o` is high while a bus transaction is outstanding, and `bus_req_o` with its command and address holds until the ack. A snoop to the same index as a waiting request raises `busy_o` in that cycle, so the snoop is applied first.
- R12: If a snoop invalidates the line while its upgrade is pending, the request becomes a read-for-ownership. If a snoop invalidates a victim while its writeback is pending, the writeback is dropped and the fetch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | TAG_W+IDX_W | Line address {tag, index} |
| req_wdata_i | input | DATA_W | Store data |
| busy_o | output | 1 | Request cannot be accepted this cycle |
| resp_valid_o | output | 1 | Request completed |
| resp_rdata_o | output | DATA_W | Load data, or store data for stores |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr_o | output | TAG_W+IDX_W | Transaction line address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_ack_i | input | 1 | Transaction completes this cycle |
| bus_shared_i | input | 1 | Another cache holds the line (valid with ack) |
| bus_rdata_i | input | DATA_W | Fill data (valid with ack) |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | TAG_W+IDX_W | Snooped line address |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache drives the line data |
| snp_data_o | output | DATA_W | Supplied data, zero when not supplying |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is a snoop and a processor request to the same index. The bench raises both in one cycle with an invalidating snoop on an Exclusive line. It then expects `busy_o` high in that cycle and a refetch once the request is accepted, which shows the request saw the invalidated line. The second pair is a snoop and a pending bus transaction. The bench leaves an upgrade, and later a writeback, waiting without an ack while it injects a read-for-ownership on that line. It then expects the next granted command to become a read-for-ownership or a plain read, with the right data supplied on the snoop.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {ST_I, ST_S, ST_E, ST_O, ST_M} line_st_e;
  typedef enum logic [1:0] {BUS_RD, BUS_RDX, BUS_UPG, BUS_WB} bus_cmd_e;

  function automatic logic is_dirty(line_st_e st);
    return (st == ST_M) || (st == ST_O);
  endfunction
endpackage

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
  import moesi_pkg::*;
(
  input  logic     valid_i,
  input  bus_cmd_e cmd_i,
  input  logic     hit_i,
  input  line_st_e cur_i,
  output line_st_e nxt_o,
  output logic     upd_o,
  output logic     shared_o,
  output logic     supply_o
);
  always_comb begin
    nxt_o    = cur_i;
    shared_o = 1'b0;
    supply_o = 1'b0;
    if (valid_i && hit_i) begin
      unique case (cmd_i)
        BUS_RD: begin
          shared_o = 1'b1;
          supply_o = is_dirty(cur_i);
          if (cur_i == ST_M) nxt_o = ST_O;
          else if (cur_i == ST_E) nxt_o = ST_S;
        end
        BUS_RDX: begin
          shared_o = 1'b1;
          supply_o = is_dirty(cur_i);
          nxt_o    = ST_I;
        end
        BUS_UPG: begin
          shared_o = 1'b1;
          nxt_o    = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign upd_o = valid_i && hit_i && (nxt_o != cur_i);
endmodule

// File: rtl/moesi_line_array.sv
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // local port
  input  logic [IDX_W-1:0]  l_idx_i,
  output logic [TAG_W-1:0]  l_tag_o,
  output line_st_e          l_st_o,
  output logic [DATA_W-1:0] l_data_o,
  input  logic              l_we_i,
  input  logic [TAG_W-1:0]  l_tag_i,
  input  line_st_e          l_st_i,
  input  logic              l_dwe_i,
  input  logic [DATA_W-1:0] l_data_i,
  // snoop port
  input  logic [IDX_W-1:0]  s_idx_i,
  output logic [TAG_W-1:0]  s_tag_o,
  output line_st_e          s_st_o,
  output logic [DATA_W-1:0] s_data_o,
  input  logic              s_we_i,
  input  line_st_e          s_st_i
);
  localparam int NLINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [NLINES];
  line_st_e          st_q   [NLINES];
  logic [DATA_W-1:0] data_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]  <= '0;
        st_q[g]   <= ST_I;
        data_q[g] <= '0;
      end else begin
        if (s_we_i && s_idx_i == IDX_W'(g)) st_q[g] <= s_st_i;
        if (l_we_i && l_idx_i == IDX_W'(g)) begin
          st_q[g]  <= l_st_i;
          tag_q[g] <= l_tag_i;
          if (l_dwe_i) data_q[g] <= l_data_i;
        end
      end
    end
  end

  assign l_tag_o  = tag_q[l_idx_i];
  assign l_st_o   = st_q[l_idx_i];
  assign l_data_o = data_q[l_idx_i];
  assign s_tag_o  = tag_q[s_idx_i];
  assign s_st_o   = st_q[s_idx_i];
  assign s_data_o = data_q[s_idx_i];
endmodule

// File: rtl/moesi_cc.sv
module moesi_cc
  import moesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [TAG_W+IDX_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   busy_o,
  output logic                   resp_valid_o,
  output logic [DATA_W-1:0]      resp_rdata_o,
  output logic                   bus_req_o,
  output logic [1:0]             bus_cmd_o,
  output logic [TAG_W+IDX_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  input  logic                   bus_ack_i,
  input  logic                   bus_shared_i,
  input  logic [DATA_W-1:0]      bus_rdata_i,
  input  logic                   snp_valid_i,
  input  logic [1:0]             snp_cmd_i,
  input  logic [TAG_W+IDX_W-1:0] snp_addr_i,
  output logic                   snp_shared_o,
  output logic                   snp_supply_o,
  output logic [DATA_W-1:0]      snp_data_o
);
  localparam int ADDR_W = TAG_W + IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_UPG} fsm_e;

  fsm_e fsm_q, fsm_d;
  logic              p_write_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;
  logic              resp_v_d;
  logic [DATA_W-1:0] resp_d;
  logic              capture;

  wire [IDX_W-1:0] req_idx = req_addr_i[IDX_W-1:0];
  wire [TAG_W-1:0] req_tag = req_addr_i[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] p_idx   = p_addr_q[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag   = p_addr_q[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx   = snp_addr_i[IDX_W-1:0];
  wire [TAG_W-1:0] s_req_tag = snp_addr_i[ADDR_W-1:IDX_W];

  logic [IDX_W-1:0]  l_idx;
  logic [TAG_W-1:0]  l_tag, s_tag, lw_tag;
  line_st_e          l_st, s_st, lw_st, s_nxt;
  logic [DATA_W-1:0] l_data, s_data, lw_data;
  logic              l_we, l_dwe, s_upd;

  assign l_idx = (fsm_q == F_IDLE) ? req_idx : p_idx;

  moesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_array (
    .clk_i, .rst_ni,
    .l_idx_i(l_idx), .l_tag_o(l_tag), .l_st_o(l_st), .l_data_o(l_data),
    .l_we_i(l_we), .l_tag_i(lw_tag), .l_st_i(lw_st), .l_dwe_i(l_dwe), .l_data_i(lw_data),
    .s_idx_i(s_idx), .s_tag_o(s_tag), .s_st_o(s_st), .s_data_o(s_data),
    .s_we_i(s_upd), .s_st_i(s_nxt)
  );

  wire s_hit = (s_st != ST_I) && (s_tag == s_req_tag);

  moesi_snoop_resp i_snoop (
    .valid_i(snp_valid_i), .cmd_i(bus_cmd_e'(snp_cmd_i)), .hit_i(s_hit), .cur_i(s_st),
    .nxt_o(s_nxt), .upd_o(s_upd), .shared_o(snp_shared_o), .supply_o(snp_supply_o)
  );
  assign snp_data_o = snp_supply_o ? s_data : '0;

  // snoop removes the line this pending transaction depends on
  wire snp_kills_p = s_upd && (s_nxt == ST_I) && (s_idx == p_idx);

  assign busy_o = (fsm_q != F_IDLE) || (snp_valid_i && s_idx == req_idx);
  wire accept   = req_valid_i && !busy_o;
  wire l_hit    = (l_st != ST_I) && (l_tag == req_tag);

  always_comb begin
    fsm_d    = fsm_q;
    capture  = 1'b0;
    resp_v_d = 1'b0;
    resp_d   = resp_rdata_o;
    l_we     = 1'b0;
    l_dwe    = 1'b0;
    lw_tag   = l_tag;
    lw_st    = l_st;
    lw_data  = p_wdata_q;
    unique case (fsm_q)
      F_IDLE: if (accept) begin
        capture = 1'b1;
        if (l_hit && !req_write_i) begin
          resp_v_d = 1'b1;
          resp_d   = l_data;
        end else if (l_hit && (l_st == ST_M || l_st == ST_E)) begin
          l_we     = 1'b1;
          l_dwe    = 1'b1;
          lw_st    = ST_M;
          lw_data  = req_wdata_i;
          resp_v_d = 1'b1;
          resp_d   = req_wdata_i;
        end else if (l_hit) begin
          fsm_d = F_UPG;
        end else begin
          fsm_d = is_dirty(l_st) ? F_WB : F_FILL;
        end
      end
      F_WB: begin
        if (snp_kills_p) fsm_d = F_FILL;
        else if (bus_ack_i) begin
          l_we  = 1'b1;
          lw_st = ST_I;
          fsm_d = F_FILL;
        end
      end
      F_FILL: if (bus_ack_i) begin
        l_we     = 1'b1;
        l_dwe    = 1'b1;
        lw_tag   = p_tag;
        lw_st    = p_write_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        lw_data  = p_write_q ? p_wdata_q : bus_rdata_i;
        resp_v_d = 1'b1;
        resp_d   = lw_data;
        fsm_d    = F_IDLE;
      end
      F_UPG: begin
        if (snp_kills_p) fsm_d = F_FILL;
        else if (bus_ack_i) begin
          l_we     = 1'b1;
          l_dwe    = 1'b1;
          lw_st    = ST_M;
          resp_v_d = 1'b1;
          resp_d   = p_wdata_q;
          fsm_d    = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q        <= F_IDLE;
      p_write_q    <= 1'b0;
      p_addr_q     <= '0;
      p_wdata_q    <= '0;
      resp_valid_o <= 1'b0;
      resp_rdata_o <= '0;
    end else begin
      fsm_q        <= fsm_d;
      resp_valid_o <= resp_v_d;
      resp_rdata_o <= resp_d;
      if (capture) begin
        p_write_q <= req_write_i;
        p_addr_q  <= req_addr_i;
        p_wdata_q <= req_wdata_i;
      end
    end
  end

  assign bus_req_o = (fsm_q != F_IDLE);
  always_comb begin
    unique case (fsm_q)
      F_WB:    bus_cmd_o = BUS_WB;
      F_UPG:   bus_cmd_o = BUS_UPG;
      F_FILL:  bus_cmd_o = p_write_q ? BUS_RDX : BUS_RD;
      default: bus_cmd_o = BUS_RD;
    endcase
  end
  assign bus_addr_o  = (fsm_q == F_WB) ? {l_tag, p_idx} : p_addr_q;
  assign bus_wdata_o = (fsm_q == F_WB) ? l_data : '0;
endmodule

// File: rtl/moesi_cc_chk.sv
module moesi_cc_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              resp_valid_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic              snp_valid_i,
  input logic [1:0]        snp_cmd_i,
  input logic              snp_shared_o,
  input logic              snp_supply_o
);
  assert_bus_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o);

  assert_bus_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !snp_valid_i |=> $stable(bus_addr_o) && $stable(bus_cmd_o));

  assert_busy_on_bus_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  assert_resp_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(bus_ack_i && bus_req_o) || $past(req_valid_i && !busy_o));

  assert_ack_completes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_cmd_o != 2'd3 |=> resp_valid_o);

  assert_wb_then_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_cmd_o == 2'd3 |=> bus_req_o && (bus_cmd_o == 2'd0 || bus_cmd_o == 2'd1));

  assert_upg_no_supply_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_cmd_i == 2'd2 |-> !snp_supply_o);

  assert_wb_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_cmd_i == 2'd3 |-> !snp_shared_o && !snp_supply_o);

  assert_supply_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_valid_i && snp_shared_o && (snp_cmd_i == 2'd0 || snp_cmd_i == 2'd1));
endmodule

bind moesi_cc moesi_cc_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .resp_valid_o(resp_valid_o), .bus_req_o(bus_req_o), .bus_cmd_o(bus_cmd_o),
  .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i), .snp_valid_i(snp_valid_i),
  .snp_cmd_i(snp_cmd_i), .snp_shared_o(snp_shared_o), .snp_supply_o(snp_supply_o)
);

// File: tb/test_moesi_cc.sv
module test_moesi_cc;
  localparam int IW = 2, TW = 4, DW = 32, AW = IW + TW;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic busy_o, resp_valid_o, bus_req_o;
  logic [DW-1:0] resp_rdata_o, bus_wdata_o, snp_data_o;
  logic [1:0] bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic bus_ack_i = 0, bus_shared_i = 0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic snp_valid_i = 0;
  logic [1:0] snp_cmd_i = '0;
  logic [AW-1:0] snp_addr_i = '0;
  logic snp_shared_o, snp_supply_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];

  always #10 clk = ~clk;

  moesi_cc #(.IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) i_moesi_cc (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .busy_o, .resp_valid_o, .resp_rdata_o, .bus_req_o, .bus_cmd_o, .bus_addr_o,
    .bus_wdata_o, .bus_ack_i, .bus_shared_i, .bus_rdata_i, .snp_valid_i, .snp_cmd_i,
    .snp_addr_i, .snp_shared_o, .snp_supply_o, .snp_data_o
  );

  function automatic logic [AW-1:0] mk(int tag, int idx);
    return {TW'(tag), IW'(idx)};
  endfunction

  task automatic check(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // monitor: pops expected responses
  always @(negedge clk) begin
    if (rst_ni && resp_valid_o) begin
      if (exp_q.size() == 0) check("R2 unexpected response", 32'h1, 32'h0);
      else check("R2/R3 response data", resp_rdata_o, exp_q.pop_front());
    end
  end

  // driver: push expected item, hold request until accepted
  task automatic cpu_issue(logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] e);
    exp_q.push_back(e);
    @(negedge clk);
    req_valid_i = 1; req_write_i = w; req_addr_i = a; req_wdata_i = d;
    forever begin
      #2;
      if (!busy_o) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid_i = 0;
  endtask

  task automatic bus_serve(string r, logic [1:0] cmd, logic [AW-1:0] a, logic sh,
                           logic [DW-1:0] rd, logic [DW-1:0] wb);
    while (!bus_req_o) @(negedge clk);
    check({r, " bus cmd"}, DW'(bus_cmd_o), DW'(cmd));
    check({r, " bus addr"}, DW'(bus_addr_o), DW'(a));
    if (cmd == C_WB) check({r, " wb data"}, bus_wdata_o, wb);
    bus_ack_i = 1; bus_shared_i = sh; bus_rdata_i = rd;
    @(negedge clk);
    bus_ack_i = 0; bus_shared_i = 0;
  endtask

  task automatic snoop(string r, logic [1:0] cmd, logic [AW-1:0] a, logic esh, logic esup,
                       logic [DW-1:0] ed);
    @(negedge clk);
    snp_valid_i = 1; snp_cmd_i = cmd; snp_addr_i = a;
    #2;
    check({r, " snp shared"}, DW'(snp_shared_o), DW'(esh));
    check({r, " snp supply"}, DW'(snp_supply_o), DW'(esup));
    if (esup) check({r, " snp data"}, snp_data_o, ed);
    @(negedge clk);
    snp_valid_i = 0;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", DW'(busy_o), 0);
    check("R1 bus_req", DW'(bus_req_o), 0);
    check("R1 resp_valid", DW'(resp_valid_o), 0);
    snoop("R1 empty", C_RD, mk(1, 0), 0, 0, 0);

    // R3 load miss, no sharer -> Exclusive
    cpu_issue(0, mk(1, 0), 0, 32'h11);
    check("R11 busy during miss", DW'(busy_o), 1);
    bus_serve("R3", C_RD, mk(1, 0), 0, 32'h11, 0);
    // R9 Exclusive -> Shared on snooped read
    snoop("R9 E", C_RD, mk(1, 0), 1, 0, 0);
    // R5 store to Shared -> upgrade
    cpu_issue(1, mk(1, 0), 32'h22, 32'h22);
    bus_serve("R5 S", C_UPG, mk(1, 0), 0, 0, 0);
    // R2 load hit, no bus
    cpu_issue(0, mk(1, 0), 0, 32'h22);
    check("R2 no bus on hit", DW'(bus_req_o), 0);
    // R8 Modified -> Owned with supply
    snoop("R8 M", C_RD, mk(1, 0), 1, 1, 32'h22);
    snoop("R9 O", C_RD, mk(1, 0), 1, 1, 32'h22);
    cpu_issue(1, mk(1, 0), 32'h33, 32'h33);
    bus_serve("R5 O", C_UPG, mk(1, 0), 0, 0, 0);

    // R3 shared fill, R9 Shared snoop, R10 upgrade invalidates
    cpu_issue(0, mk(2, 1), 0, 32'h44);
    bus_serve("R3 shared", C_RD, mk(2, 1), 1, 32'h44, 0);
    snoop("R9 S", C_RD, mk(2, 1), 1, 0, 0);
    snoop("R10 upg", C_UPG, mk(2, 1), 1, 0, 0);
    cpu_issue(0, mk(2, 1), 0, 32'h46);
    bus_serve("R10 refetch", C_RD, mk(2, 1), 0, 32'h46, 0);
    // R4 silent store on Exclusive
    cpu_issue(1, mk(2, 1), 32'h47, 32'h47);
    check("R4 no bus", DW'(bus_req_o), 0);
    snoop("R10 rdx M", C_RDX, mk(2, 1), 1, 1, 32'h47);
    snoop("R10 after inval", C_RD, mk(2, 1), 0, 0, 0);
    snoop("R10 wb ignored", C_WB, mk(1, 0), 0, 0, 0);

    // R6 store miss
    cpu_issue(1, mk(3, 2), 32'h55, 32'h55);
    bus_serve("R6", C_RDX, mk(3, 2), 0, 32'hdead, 0);
    cpu_issue(0, mk(3, 2), 0, 32'h55);
    check("R6 hit no bus", DW'(bus_req_o), 0);
    // R7 dirty eviction, then clean eviction
    cpu_issue(0, mk(4, 2), 0, 32'h66);
    bus_serve("R7 M wb", C_WB, mk(3, 2), 0, 0, 32'h55);
    bus_serve("R7 fetch", C_RD, mk(4, 2), 0, 32'h66, 0);
    cpu_issue(0, mk(5, 2), 0, 32'h77);
    bus_serve("R7 clean", C_RD, mk(5, 2), 0, 32'h77, 0);
    // R7 Owned eviction
    snoop("R8 M2", C_RD, mk(1, 0), 1, 1, 32'h33);
    cpu_issue(0, mk(6, 0), 0, 32'h61);
    bus_serve("R7 O wb", C_WB, mk(1, 0), 0, 0, 32'h33);
    bus_serve("R7 O fetch", C_RD, mk(6, 0), 0, 32'h61, 0);

    // R12 upgrade turned into read-for-ownership
    cpu_issue(0, mk(7, 3), 0, 32'h88);
    bus_serve("R12 setup", C_RD, mk(7, 3), 1, 32'h88, 0);
    cpu_issue(1, mk(7, 3), 32'h99, 32'h99);
    check("R12 pending upg", DW'(bus_cmd_o), DW'(C_UPG));
    snoop("R12 kill S", C_RDX, mk(7, 3), 1, 0, 0);
    bus_serve("R12 upg->rdx", C_RDX, mk(7, 3), 0, 32'haa, 0);
    snoop("R12 holds M", C_RDX, mk(7, 3), 1, 1, 32'h99);
    // R12 writeback dropped
    cpu_issue(1, mk(8, 3), 32'h12, 32'h12);
    bus_serve("R6 setup", C_RDX, mk(8, 3), 0, 0, 0);
    cpu_issue(0, mk(9, 3), 0, 32'h9a);
    check("R12 pending wb", DW'(bus_cmd_o), DW'(C_WB));
    snoop("R12 kill victim", C_RDX, mk(8, 3), 1, 1, 32'h12);
    bus_serve("R12 wb dropped", C_RD, mk(9, 3), 0, 32'h9a, 0);

    // R11 snoop and request to the same index in one cycle
    cpu_issue(0, mk(2, 1), 0, 32'hb1);
    bus_serve("R11 setup", C_RD, mk(2, 1), 0, 32'hb1, 0);
    exp_q.push_back(32'hb2);
    @(negedge clk);
    snp_valid_i = 1; snp_cmd_i = C_RDX; snp_addr_i = mk(2, 1);
    req_valid_i = 1; req_write_i = 0; req_addr_i = mk(2, 1);
    #2;
    check("R11 busy on snoop", DW'(busy_o), 1);
    check("R11 snp shared", DW'(snp_shared_o), 1);
    check("R11 snp no supply", DW'(snp_supply_o), 0);
    @(negedge clk);
    snp_valid_i = 0;
    #2;
    check("R11 busy released", DW'(busy_o), 0);
    @(negedge clk);
    req_valid_i = 0;
    bus_serve("R11 sees inval", C_RD, mk(2, 1), 0, 32'hb2, 0);

    repeat (4) @(negedge clk);
    check("R2 all responses", DW'(exp_q.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule